// File: doc/BRIEF.md
# Dual-Loop Fixed-Point PID Thermal Limiter

This block closes two discrete-time PID loops that keep the memory subsystem below its thermal limits. One loop watches the memory buffer chip and the other watches the DRAM devices. Once per control interval a strobe arrives with a fresh temperature reading for each component, in signed tenths of a degree Celsius. Each loop turns its reading into an error against its own target, builds a PID output in fixed point and maps that output onto one of five throttle levels. The more restrictive of the two levels is registered as the actuator setting. The setting is read as a fraction of full processor activity, for example the number of active cores or an operating-point index.

The loops run at a fixed interval of 10 ms. The interval is folded into the gain constants, so the hardware only adds, multiplies and shifts. The integral term grows only while the component is close to its limit, and it is frozen whenever the previous decision pinned the actuator at either end of its range. This keeps the integral from winding up.

Top module: `thermal_pid_pair`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, and after it is released until the first strobe, `setting` is 4 and `limiter` is 0. Reset also clears both loops: their integral sums, their previous errors and their saturation flags.
- R2: Each loop's error is its target minus its measured temperature, in tenths of a degree. The target is 1098 for the buffer chip and 848 for the DRAM.
- R3: On each strobe a loop forms acc = KP*e + KI*S + KD*d, where e is the error, S is the integral sum after this strobe's update and d is the error minus the error of the previous strobe. The first strobe after reset uses d = 0. The output is m = acc arithmetically shifted right by 12. The constants are KP=42598, KI=7383, KD=410 for the buffer chip and KP=50790, KI=6354, KD=410 for the DRAM.
- R4: The integral sum S gains the current error only when the measured temperature is strictly above 1090 (buffer chip) or 840 (DRAM). Otherwise S is held.
- R5: A loop is saturated when its last output satisfied m <= 0 or m >= 64. On a strobe that follows a saturated output, S is held whatever the temperature. The sum is clamped to +/-524287.
- R6: The level of a loop is 0 when m <= 0, 4 when m >= 64, and m shifted right by 4 otherwise (bands of 16). The levels 1 to 4 mean 25 % to 100 % activity, and level 0 means stop.
- R7: `setting` takes the lower of the two levels. `limiter` is 1 when the DRAM level is strictly lower than the buffer-chip level, and 0 otherwise (including ties).
- R8: `setting` and `limiter` change only at a clock edge where `tick` is high. Temperature changes without a strobe have no effect on the outputs or on the loop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Control-interval strobe, one cycle wide |
| temp_buf | input | 12 | Buffer-chip temperature, signed, 0.1 degC units |
| temp_dram | input | 12 | DRAM temperature, signed, 0.1 degC units |
| setting | output | 3 | Registered throttle level 0..4 |
| limiter | output | 1 | 1 when the DRAM loop decided the setting |

## Verification
Some properties are checked by assertions on every cycle. The integral holds between strobes, and it holds at or below the threshold and after a saturated output. The registered setting never exceeds level 4, it equals one of the two loop levels and never exceeds either, and it stays still without a strobe. The exact arithmetic can only be shown by the bench's strobe sequences, which the bench compares with its own model of the requirements. These sequences cover the integral climbing until it saturates and then freezing, the integral draining while the temperature sits just above target, a reading exactly at the threshold whose effect shows only on later strobes, the DRAM taking over as limiter, and a tie. Only directed scenarios can show that a reset clears the stored history and that temperature changes between strobes are ignored.

// File: rtl/thermal_pid_pkg.sv
package thermal_pid_pkg;

    localparam int TEMP_W  = 12;
    localparam int ERR_W   = TEMP_W + 1;
    localparam int DIF_W   = TEMP_W + 2;
    localparam int INT_W   = 20;
    localparam int GAIN_W  = 18;
    localparam int FRAC    = 12;
    localparam int BAND_SH = 4;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL + 1);
    localparam int ACC_W   = INT_W + GAIN_W + 4;
    localparam int M_TOP   = NUM_LVL << BAND_SH;
    localparam int I_MAX   = (1 << (INT_W - 1)) - 1;

    typedef logic signed [TEMP_W-1:0] temp_t;
    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic signed [DIF_W-1:0]  dif_t;
    typedef logic signed [INT_W-1:0]  isum_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [LVL_W-1:0]         lvl_t;

    typedef struct packed {
        logic signed [GAIN_W-1:0] kp;
        logic signed [GAIN_W-1:0] ki;
        logic signed [GAIN_W-1:0] kd;
    } gains_t;

    typedef enum logic {
        SRC_BUF  = 1'b0,
        SRC_DRAM = 1'b1
    } src_e;

    // Gains scaled by 2^FRAC with the 10 ms interval folded in
    localparam gains_t BUF_GAINS  = '{kp: 18'sd42598, ki: 18'sd7383, kd: 18'sd410};
    localparam gains_t DRAM_GAINS = '{kp: 18'sd50790, ki: 18'sd6354, kd: 18'sd410};

    localparam temp_t BUF_TARGET  = 12'sd1098;
    localparam temp_t BUF_THRESH  = 12'sd1090;
    localparam temp_t DRAM_TARGET = 12'sd848;
    localparam temp_t DRAM_THRESH = 12'sd840;

    function automatic isum_t isum_add(isum_t a, err_t e);
        logic signed [INT_W:0] s;
        s = (INT_W+1)'(a) + (INT_W+1)'(e);
        if (s > (INT_W+1)'(I_MAX))
            return isum_t'(I_MAX);
        else if (s < -(INT_W+1)'(I_MAX))
            return -isum_t'(I_MAX);
        else
            return isum_t'(s);
    endfunction

    function automatic lvl_t to_level(acc_t m);
        if (m <= 0)
            return '0;
        else if (m >= acc_t'(M_TOP))
            return lvl_t'(NUM_LVL);
        else
            return lvl_t'(m[BAND_SH +: LVL_W]);
    endfunction

endpackage

// File: rtl/thermal_pid_loop.sv
module thermal_pid_loop
    import thermal_pid_pkg::*;
#(
    parameter temp_t  TARGET = BUF_TARGET,
    parameter temp_t  THRESH = BUF_THRESH,
    parameter gains_t GAINS  = BUF_GAINS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  temp_t temp,
    output lvl_t  level
);

    err_t  err, err_prev_q;
    dif_t  dif;
    isum_t isum_q, isum_nx;
    logic  first_q, sat_q, sat_now, integ_en;
    acc_t  p_kp, p_ki, p_kd, acc, m;

    assign err      = ERR_W'(TARGET) - ERR_W'(temp);
    assign dif      = first_q ? '0 : (DIF_W'(err) - DIF_W'(err_prev_q));
    assign integ_en = (temp > THRESH) && !sat_q;
    assign isum_nx  = integ_en ? isum_add(isum_q, err) : isum_q;

    assign p_kp = ACC_W'(GAINS.kp) * ACC_W'(err);
    assign p_ki = ACC_W'(GAINS.ki) * ACC_W'(isum_nx);
    assign p_kd = ACC_W'(GAINS.kd) * ACC_W'(dif);
    assign acc  = p_kp + p_ki + p_kd;
    assign m    = acc >>> FRAC;

    assign sat_now = (m <= 0) || (m >= acc_t'(M_TOP));
    assign level   = to_level(m);

    always_ff @(posedge clk) begin
        if (rst) begin
            isum_q     <= '0;
            err_prev_q <= '0;
            first_q    <= 1'b1;
            sat_q      <= 1'b0;
        end else if (tick) begin
            isum_q     <= isum_nx;
            err_prev_q <= err;
            first_q    <= 1'b0;
            sat_q      <= sat_now;
        end
    end

    // R4
    below_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && temp <= THRESH) |=> $stable(isum_q));

    // R5
    no_windup_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sat_q) |=> $stable(isum_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(isum_q) && $stable(err_prev_q)));

    // R6
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        level <= lvl_t'(NUM_LVL));

endmodule

// File: rtl/thermal_pick_min.sv
module thermal_pick_min
    import thermal_pid_pkg::*;
(
    input  lvl_t lvl_buf,
    input  lvl_t lvl_dram,
    output lvl_t pick,
    output src_e src
);

    always_comb begin
        if (lvl_dram < lvl_buf) begin
            pick = lvl_dram;
            src  = SRC_DRAM;
        end else begin
            pick = lvl_buf;
            src  = SRC_BUF;
        end
    end

endmodule

// File: rtl/thermal_pid_pair.sv
module thermal_pid_pair
    import thermal_pid_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic signed [TEMP_W-1:0] temp_buf,
    input  logic signed [TEMP_W-1:0] temp_dram,
    output logic [LVL_W-1:0]         setting,
    output logic                     limiter
);

    lvl_t lvl_b, lvl_d, pick;
    src_e src;

    thermal_pid_loop #(
        .TARGET(BUF_TARGET), .THRESH(BUF_THRESH), .GAINS(BUF_GAINS)
    ) u_loop_buf (
        .clk(clk), .rst(rst), .tick(tick), .temp(temp_buf), .level(lvl_b)
    );

    thermal_pid_loop #(
        .TARGET(DRAM_TARGET), .THRESH(DRAM_THRESH), .GAINS(DRAM_GAINS)
    ) u_loop_dram (
        .clk(clk), .rst(rst), .tick(tick), .temp(temp_dram), .level(lvl_d)
    );

    thermal_pick_min u_pick (
        .lvl_buf(lvl_b), .lvl_dram(lvl_d), .pick(pick), .src(src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            setting <= lvl_t'(NUM_LVL);
            limiter <= 1'b0;
        end else if (tick) begin
            setting <= pick;
            limiter <= (src == SRC_DRAM);
        end
    end

    // R8
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(setting) && $stable(limiter)));

    // R7
    most_restrictive_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((setting <= $past(lvl_b)) && (setting <= $past(lvl_d))
                  && ((setting == $past(lvl_b)) || (setting == $past(lvl_d)))));

    // R6
    setting_range_chk: assert property (@(posedge clk) disable iff (rst)
        setting <= lvl_t'(NUM_LVL));

endmodule

// File: tb/test_thermal_pid_pair.sv
module test_thermal_pid_pair;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic signed [11:0] temp_buf = '0;
    logic signed [11:0] temp_dram = '0;
    logic [2:0]        setting;
    logic              limiter;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    thermal_pid_pair i_thermal_pid_pair (
        .clk(clk), .rst(rst), .tick(tick),
        .temp_buf(temp_buf), .temp_dram(temp_dram),
        .setting(setting), .limiter(limiter)
    );

    // Stimulus rows {buffer temp, DRAM temp}; expected results come from the model below
    localparam int NROW = 17;
    localparam int ROWS [NROW][2] = '{
        '{1095, 700}, '{1095, 700}, '{1095, 700}, '{1095, 700},   // R4 integral climbing
        '{1095, 700}, '{1095, 700}, '{1095, 700},                 // R5 reaches saturation
        '{1099, 700}, '{1099, 700},                               // R5 frozen then draining
        '{1090, 700},                                             // R4 exactly at threshold
        '{1099, 700}, '{1099, 700},
        '{1000, 846}, '{1000, 846},                               // R7 DRAM limits
        '{1000, 860},                                             // R7 DRAM stops
        '{1120, 860},                                             // R7 tie at level 0
        '{ 900, 700}
    };

    localparam int TGT [2] = '{1098, 848};
    localparam int THR [2] = '{1090, 840};
    localparam int KP  [2] = '{42598, 50790};
    localparam int KI  [2] = '{7383, 6354};
    localparam int KD  [2] = '{410, 410};

    int isum [2];
    int eprev [2];
    bit first [2];
    bit satq [2];

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            isum[k] = 0; eprev[k] = 0; first[k] = 1; satq[k] = 0;
        end
    endtask

    task automatic model_step(input int k, input int t, output int lvl);
        int e, d, isn;
        longint acc, m;
        e = TGT[k] - t;                             // R2
        d = first[k] ? 0 : e - eprev[k];
        isn = isum[k];
        if (t > THR[k] && !satq[k]) begin           // R4, R5
            isn = isn + e;
            if (isn > 524287) isn = 524287;
            if (isn < -524287) isn = -524287;
        end
        acc = longint'(KP[k]) * e + longint'(KI[k]) * isn + longint'(KD[k]) * d;  // R3
        m = acc >>> 12;
        if (m <= 0) lvl = 0;                        // R6
        else if (m >= 64) lvl = 4;
        else lvl = int'(m >>> 4);
        satq[k] = (m <= 0) || (m >= 64);
        isum[k] = isn; eprev[k] = e; first[k] = 0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int tb, input int td, input string req);
        int lb, ld, es, el;
        @(negedge clk);
        temp_buf = 12'(tb); temp_dram = 12'(td); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_step(0, tb, lb);
        model_step(1, td, ld);
        el = (ld < lb) ? 1 : 0;                     // R7
        es = el ? ld : lb;
        check({req, " setting"}, int'(setting), es);
        check({req, " limiter"}, int'(limiter), el);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int s0, l0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset setting", int'(setting), 4);
        check("R1 reset limiter", int'(limiter), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset setting", int'(setting), 4);

        for (int r = 0; r < NROW; r++)
            strobe(ROWS[r][0], ROWS[r][1], $sformatf("R3 R6 R7 row %0d", r));

        // R8: temperature swings with no strobe are ignored
        s0 = int'(setting); l0 = int'(limiter);
        @(negedge clk);
        temp_buf = 12'sd1500; temp_dram = 12'sd300;
        repeat (6) @(negedge clk);
        temp_buf = 12'sd1098; temp_dram = 12'sd848;
        repeat (3) @(negedge clk);
        check("R8 hold setting", int'(setting), s0);
        check("R8 hold limiter", int'(limiter), l0);
        strobe(1095, 846, "R8 state untouched by idle swings");

        // R1: reset in mid-run clears outputs and loop history
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset setting", int'(setting), 4);
        check("R1 mid-run reset limiter", int'(limiter), 0);
        rst = 1'b0;
        model_reset();
        strobe(1095, 846, "R1 history cleared");
        strobe(1095, 846, "R1 history cleared second");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule